// File: doc/BRIEF.md
# Transmit/Receive FIFO Pair with DMA Burst Requests

This block holds the two data queues that sit between a two-wire serial bus controller and the system: a transmit queue of 11-bit command words (8 data bits plus direction, stop and restart flags) and a receive queue of 8-bit bytes, each 24 entries deep by default. The system side fills the transmit queue and empties the receive queue. The bus engine does the opposite. Each queue reports its fill level, full and empty, and keeps sticky flags for a write into a full queue and a read from an empty one.

Each queue also drives a level-sensitive burst request towards a DMA engine. The transmit request asks for a refill while the level is at or below a programmable threshold. The receive request asks for a drain once the level reaches the receive threshold plus one. When the DMA engine acknowledges a raised request, the request drops and stays low while the engine moves the programmed burst count of words through the queue's system-side port. After the last of those transfers the request is evaluated again from the current level. With the transmit threshold at depth minus burst and the receive threshold at burst minus one, a whole burst always fits into the transmit queue, and a whole burst is always available in the receive queue.

Top module: `i2c_fifo_dma`

## Requirements
- R1: After reset both levels are 0, both empty outputs are 1, all four sticky flags are 0, the receive request is 0 and the transmit request is 1 for every threshold value.
- R2: Each queue returns its words in write order. The level counts accepted writes minus accepted reads and ranges from 0 to DEPTH (24). Full is 1 exactly at level DEPTH, and empty is 1 exactly at level 0. Transmit words keep all 11 bits, and receive words keep all 8 bits.
- R3: A write strobe that arrives while the queue is full is dropped: level and contents stay unchanged. It also sets that queue's overflow flag (`tx_ovf` or `rx_ovf`), which then stays 1 until reset.
- R4: A read strobe that arrives while the queue is empty is dropped. It sets that queue's underflow flag (`tx_udf` or `rx_udf`), which then stays 1 until reset.
- R5: While no burst is in progress, `tx_dma_req` equals (tx_level <= tx_thresh), and this holds for every threshold from 0 to DEPTH.
- R6: While no burst is in progress, `rx_dma_req` equals (rx_level >= rx_thresh + 1). With a threshold of DEPTH the request never rises.
- R7: If the acknowledge is high in a cycle where the request is high and `burst_len` is nonzero, a burst starts and the request is 0 from the next cycle onwards, whatever the level. An acknowledge while the request is low has no effect.
- R8: A burst ends with the `burst_len`-th system-side strobe: `tx_wr_en` for the transmit queue, `rx_rd_en` for the receive queue. From the next cycle the request again follows R5 or R6.
- R9: When a write and a read arrive in the same cycle, each is judged against the level at the start of that cycle. Between empty and full both are taken and the level stays the same. At empty only the write is taken and underflow is set. At full only the read is taken and overflow is set.
- R10: An acknowledge while `burst_len` is 0 starts no burst, and the request keeps following the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_thresh | input | 5 | Transmit refill threshold |
| rx_thresh | input | 5 | Receive drain threshold |
| burst_len | input | 5 | Words moved per DMA burst |
| tx_wr_en | input | 1 | System/DMA write strobe into transmit queue |
| tx_wr_data | input | 11 | Transmit command word |
| tx_rd_en | input | 1 | Bus engine read strobe from transmit queue |
| tx_rd_data | output | 11 | Head of transmit queue |
| tx_level | output | 5 | Transmit fill level |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_udf | output | 1 | Sticky transmit underflow |
| tx_dma_req | output | 1 | Transmit refill burst request |
| tx_dma_ack | input | 1 | Transmit burst acknowledge |
| rx_wr_en | input | 1 | Bus engine write strobe into receive queue |
| rx_wr_data | input | 8 | Received byte |
| rx_rd_en | input | 1 | System/DMA read strobe from receive queue |
| rx_rd_data | output | 8 | Head of receive queue |
| rx_level | output | 5 | Receive fill level |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_udf | output | 1 | Sticky receive underflow |
| rx_dma_req | output | 1 | Receive drain burst request |
| rx_dma_ack | input | 1 | Receive burst acknowledge |

## Verification
The bench fills each queue one word at a time. At every level from 0 to 24 it sweeps the threshold over all 25 values, so an off-by-one in either comparison, or the transmit and receive comparisons swapped, shows up at one exact level/threshold pair. It pushes past full and reads past empty, and it issues simultaneous write and read at empty, mid-level and full. A design that admits a write at full would corrupt the head word. A design that judges the pair against the updated level would take or drop the wrong one. Burst runs check that the request stays low through the burst even when the level still satisfies the threshold, that it comes back exactly one cycle after the last counted strobe, and that an acknowledge given with a zero burst count or a low request is ignored.

// File: rtl/fifo_dma_pkg.sv
package fifo_dma_pkg;
  localparam int unsigned DEF_DEPTH = 24;
  localparam int unsigned TX_WORD_W = 11;
  localparam int unsigned RX_WORD_W = 8;

  typedef enum logic {
    REQ_IDLE  = 1'b0,
    REQ_BURST = 1'b1
  } req_state_e;
endpackage

// File: rtl/dfd_fifo_core.sv
module dfd_fifo_core #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 24,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             ovf,
  output logic             udf
);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             ovf_q, ovf_d;
  logic             udf_q, udf_d;
  logic             push_ok, pop_ok;

  always_comb begin
    push_ok  = wr_en && (lvl_q != LVL_MAX);
    pop_ok   = rd_en && (lvl_q != '0);
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push_ok) wr_ptr_d = (wr_ptr_q == PTR_MAX) ? '0 : wr_ptr_q + PTR_W'(1);
    if (pop_ok)  rd_ptr_d = (rd_ptr_q == PTR_MAX) ? '0 : rd_ptr_q + PTR_W'(1);
    unique case ({push_ok, pop_ok})
      2'b10:   lvl_d = lvl_q + LVL_W'(1);
      2'b01:   lvl_d = lvl_q - LVL_W'(1);
      default: lvl_d = lvl_q;
    endcase
    ovf_d = ovf_q || (wr_en && !push_ok);
    udf_d = udf_q || (rd_en && !pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      lvl_q    <= lvl_d;
      ovf_q    <= ovf_d;
      udf_q    <= udf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= wr_data;
  end

  assign rd_data = mem_q[rd_ptr_q];
  assign level   = lvl_q;
  assign full    = (lvl_q == LVL_MAX);
  assign empty   = (lvl_q == '0);
  assign ovf     = ovf_q;
  assign udf     = udf_q;
endmodule

// File: rtl/dfd_req_ctrl.sv
module dfd_req_ctrl
  import fifo_dma_pkg::*;
#(
  parameter int unsigned LVL_W = 5,
  parameter bit          IS_RX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  input  logic [LVL_W-1:0] burst_len,
  input  logic             ack,
  input  logic             xfer,
  output logic             req
);
  req_state_e       st_q, st_d;
  logic [LVL_W-1:0] cnt_q, cnt_d;
  logic [LVL_W-1:0] cnt_inc;
  logic             lvl_hit;

  generate
    if (IS_RX) begin : g_drain
      logic [LVL_W:0] lvl_ext, trig_ext;
      always_comb begin
        lvl_ext  = {1'b0, level};
        trig_ext = {1'b0, thresh} + {{LVL_W{1'b0}}, 1'b1};
        lvl_hit  = (lvl_ext >= trig_ext);
      end
    end else begin : g_refill
      always_comb lvl_hit = (level <= thresh);
    end
  endgenerate

  assign req     = (st_q == REQ_IDLE) && lvl_hit;
  assign cnt_inc = cnt_q + LVL_W'(1);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      REQ_IDLE: begin
        if (req && ack && (burst_len != '0)) begin
          st_d  = REQ_BURST;
          cnt_d = '0;
        end
      end
      REQ_BURST: begin
        if (xfer) begin
          if (cnt_inc == burst_len) st_d = REQ_IDLE;
          cnt_d = cnt_inc;
        end
      end
      default: st_d = REQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= REQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/i2c_fifo_dma.sv
module i2c_fifo_dma
  import fifo_dma_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned TX_W  = TX_WORD_W,
  parameter int unsigned RX_W  = RX_WORD_W,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic [LVL_W-1:0] rx_thresh,
  input  logic [LVL_W-1:0] burst_len,
  input  logic             tx_wr_en,
  input  logic [TX_W-1:0]  tx_wr_data,
  input  logic             tx_rd_en,
  output logic [TX_W-1:0]  tx_rd_data,
  output logic [LVL_W-1:0] tx_level,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             tx_ovf,
  output logic             tx_udf,
  output logic             tx_dma_req,
  input  logic             tx_dma_ack,
  input  logic             rx_wr_en,
  input  logic [RX_W-1:0]  rx_wr_data,
  input  logic             rx_rd_en,
  output logic [RX_W-1:0]  rx_rd_data,
  output logic [LVL_W-1:0] rx_level,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             rx_ovf,
  output logic             rx_udf,
  output logic             rx_dma_req,
  input  logic             rx_dma_ack
);
  dfd_fifo_core #(.W(TX_W), .DEPTH(DEPTH)) tx_fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tx_wr_en),
    .wr_data (tx_wr_data),
    .rd_en   (tx_rd_en),
    .rd_data (tx_rd_data),
    .level   (tx_level),
    .full    (tx_full),
    .empty   (tx_empty),
    .ovf     (tx_ovf),
    .udf     (tx_udf)
  );

  dfd_fifo_core #(.W(RX_W), .DEPTH(DEPTH)) rx_fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rx_wr_en),
    .wr_data (rx_wr_data),
    .rd_en   (rx_rd_en),
    .rd_data (rx_rd_data),
    .level   (rx_level),
    .full    (rx_full),
    .empty   (rx_empty),
    .ovf     (rx_ovf),
    .udf     (rx_udf)
  );

  dfd_req_ctrl #(.LVL_W(LVL_W), .IS_RX(1'b0)) tx_req_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (tx_level),
    .thresh    (tx_thresh),
    .burst_len (burst_len),
    .ack       (tx_dma_ack),
    .xfer      (tx_wr_en),
    .req       (tx_dma_req)
  );

  dfd_req_ctrl #(.LVL_W(LVL_W), .IS_RX(1'b1)) rx_req_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (rx_level),
    .thresh    (rx_thresh),
    .burst_len (burst_len),
    .ack       (rx_dma_ack),
    .xfer      (rx_rd_en),
    .req       (rx_dma_req)
  );
endmodule

// File: rtl/i2c_fifo_dma_checker.sv
module i2c_fifo_dma_checker #(
  parameter int unsigned DEPTH = 24,
  parameter int unsigned LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] tx_thresh,
  input logic [LVL_W-1:0] rx_thresh,
  input logic [LVL_W-1:0] burst_len,
  input logic             tx_wr_en,
  input logic             tx_rd_en,
  input logic [LVL_W-1:0] tx_level,
  input logic             tx_full,
  input logic             tx_empty,
  input logic             tx_ovf,
  input logic             tx_dma_req,
  input logic             tx_dma_ack,
  input logic             rx_wr_en,
  input logic             rx_rd_en,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_udf,
  input logic             rx_empty,
  input logic             rx_dma_req,
  input logic             rx_dma_ack
);
  // R2
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_en && tx_full && !tx_rd_en) |=> (tx_ovf && $stable(tx_level)));

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_ovf);

  // R4
  udf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_en && rx_empty && !rx_wr_en) |=> (rx_udf && (rx_level == '0)));

  // R5
  tx_req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> (tx_level <= tx_thresh));

  // R6
  rx_req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> ({1'b0, rx_level} > {1'b0, rx_thresh}));

  // R7
  tx_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dma_req && tx_dma_ack && (burst_len != '0)) |=> !tx_dma_req);

  // R7
  rx_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dma_req && rx_dma_ack && (burst_len != '0)) |=> !rx_dma_req);

  // R9
  pair_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_en && tx_rd_en && !tx_full && !tx_empty) |=> $stable(tx_level));
endmodule

bind i2c_fifo_dma i2c_fifo_dma_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (.*);

// File: tb/i2c_fifo_dma_tb_top.sv
module i2c_fifo_dma_tb_top;
  localparam int DEPTH = 24;
  localparam int LW    = 5;

  logic          clk;
  logic          rst_n;
  logic [LW-1:0] tx_thresh, rx_thresh, burst_len;
  logic          tx_wr_en, tx_rd_en, tx_dma_ack;
  logic [10:0]   tx_wr_data, tx_rd_data;
  logic [LW-1:0] tx_level, rx_level;
  logic          tx_full, tx_empty, tx_ovf, tx_udf, tx_dma_req;
  logic          rx_wr_en, rx_rd_en, rx_dma_ack;
  logic [7:0]    rx_wr_data, rx_rd_data;
  logic          rx_full, rx_empty, rx_ovf, rx_udf, rx_dma_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  i2c_fifo_dma dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    tx_wr_en = 0; tx_rd_en = 0; rx_wr_en = 0; rx_rd_en = 0;
    tx_dma_ack = 0; rx_dma_ack = 0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    tx_wr_en = 0; tx_rd_en = 0; rx_wr_en = 0; rx_rd_en = 0;
    tx_dma_ack = 0; rx_dma_ack = 0;
    tx_wr_data = '0; rx_wr_data = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    #1;
  endtask

  function automatic logic [10:0] txw(input int i);
    return 11'((i * 37 + 5) % 2048);
  endfunction
  function automatic logic [7:0] rxw(input int i);
    return 8'((i * 29 + 3) % 256);
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tx_thresh = 5'd3; rx_thresh = 5'd3; burst_len = 5'd8;
    do_reset();

    // R1 reset state
    chk(tx_level == 0 && rx_level == 0, "R1 levels", tx_level + rx_level, 0);
    chk(tx_empty && rx_empty, "R1 empty", {tx_empty, rx_empty}, 3);
    chk({tx_ovf, tx_udf, rx_ovf, rx_udf} == 0, "R1 flags",
        {tx_ovf, tx_udf, rx_ovf, rx_udf}, 0);
    chk(tx_dma_req && !rx_dma_req, "R1 requests", {tx_dma_req, rx_dma_req}, 2);

    // R5 / R6 / R2 sweep of level x threshold
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int th = 0; th <= DEPTH; th++) begin
        tx_thresh = LW'(th); rx_thresh = LW'(th);
        #1;
        chk(tx_dma_req == (lvl <= th), "R5 tx req", tx_dma_req, int'(lvl <= th));
        chk(rx_dma_req == (lvl >= th + 1), "R6 rx req", rx_dma_req, int'(lvl >= th + 1));
      end
      chk(tx_level == lvl && rx_level == lvl, "R2 level", tx_level, lvl);
      chk(tx_full == (lvl == DEPTH) && rx_full == (lvl == DEPTH), "R2 full", tx_full, int'(lvl == DEPTH));
      chk(tx_empty == (lvl == 0), "R2 empty", tx_empty, int'(lvl == 0));
      chk(!tx_ovf && !rx_ovf, "R3 no ovf yet", tx_ovf, 0);
      tx_wr_en = 1; tx_wr_data = txw(lvl);
      rx_wr_en = 1; rx_wr_data = rxw(lvl);
      cyc();
    end
    // the 25th push hit a full queue
    chk(tx_level == DEPTH && rx_level == DEPTH, "R3 level held", tx_level, DEPTH);
    chk(tx_ovf && rx_ovf, "R3 ovf set", {tx_ovf, rx_ovf}, 3);
    tx_wr_en = 1; tx_wr_data = 11'h7ff; cyc();
    chk(tx_ovf, "R3 ovf sticky", tx_ovf, 1);

    // R2 order and full width, R3 contents unchanged
    for (int i = 0; i < DEPTH; i++) begin
      chk(tx_rd_data == txw(i), "R2 tx order", tx_rd_data, txw(i));
      chk(rx_rd_data == rxw(i), "R2 rx order", rx_rd_data, rxw(i));
      tx_rd_en = 1; rx_rd_en = 1; cyc();
    end
    chk(tx_empty && rx_empty, "R2 drained", {tx_empty, rx_empty}, 3);
    chk(!tx_udf && !rx_udf, "R4 no udf yet", {tx_udf, rx_udf}, 0);
    tx_rd_en = 1; rx_rd_en = 1; cyc();
    chk(tx_udf && rx_udf, "R4 udf set", {tx_udf, rx_udf}, 3);
    chk(tx_level == 0 && rx_level == 0, "R4 level held", tx_level, 0);
    cyc();
    chk(tx_udf && rx_udf, "R4 udf sticky", {tx_udf, rx_udf}, 3);

    // R9 simultaneous write and read
    do_reset();
    tx_wr_en = 1; tx_rd_en = 1; tx_wr_data = txw(100); cyc();
    chk(tx_level == 1, "R9 empty pair level", tx_level, 1);
    chk(tx_udf, "R9 empty pair udf", tx_udf, 1);
    chk(tx_rd_data == txw(100), "R9 empty pair data", tx_rd_data, txw(100));
    for (int i = 1; i < 3; i++) begin
      tx_wr_en = 1; tx_wr_data = txw(100 + i); cyc();
    end
    tx_wr_en = 1; tx_rd_en = 1; tx_wr_data = txw(103); cyc();
    chk(tx_level == 3, "R9 mid pair level", tx_level, 3);
    chk(tx_rd_data == txw(101), "R9 mid pair head", tx_rd_data, txw(101));
    chk(!tx_ovf, "R9 mid pair no ovf", tx_ovf, 0);
    for (int i = 4; i < 25; i++) begin
      tx_wr_en = 1; tx_wr_data = txw(100 + i); cyc();
    end
    chk(tx_full, "R9 reach full", tx_level, DEPTH);
    tx_wr_en = 1; tx_rd_en = 1; tx_wr_data = 11'h555; cyc();
    chk(tx_level == DEPTH - 1, "R9 full pair level", tx_level, DEPTH - 1);
    chk(tx_ovf, "R9 full pair ovf", tx_ovf, 1);
    for (int i = 2; i < 25; i++) begin
      chk(tx_rd_data == txw(100 + i), "R9 full pair order", tx_rd_data, txw(100 + i));
      tx_rd_en = 1; cyc();
    end
    chk(tx_empty, "R9 dropped word absent", tx_level, 0);

    // R7 / R8 transmit bursts, threshold = depth - burst
    do_reset();
    burst_len = 5'd8; tx_thresh = 5'd16;
    for (int b = 0; b < 3; b++) begin
      chk(tx_dma_req, "R8 tx req before burst", tx_dma_req, 1);
      tx_dma_ack = 1; cyc();
      chk(!tx_dma_req, "R7 tx req dropped", tx_dma_req, 0);
      for (int k = 0; k < 8; k++) begin
        if (k > 0) chk(!tx_dma_req, "R7 tx req low in burst", tx_dma_req, 0);
        tx_wr_en = 1; tx_wr_data = txw(b * 8 + k); cyc();
      end
      chk(tx_level == (b + 1) * 8, "R8 tx level after burst", tx_level, (b + 1) * 8);
      chk(tx_dma_req == ((b + 1) * 8 <= 16), "R8 tx req reevaluated",
          tx_dma_req, int'((b + 1) * 8 <= 16));
    end
    chk(!tx_ovf, "R8 tx burst no ovf", tx_ovf, 0);
    tx_dma_ack = 1; cyc();
    for (int k = 0; k < 8; k++) begin
      chk(!tx_dma_req, "R7 ack while low", tx_dma_req, 0);
      tx_rd_en = 1; cyc();
    end
    chk(tx_dma_req, "R7 ack while low ignored", tx_dma_req, 1);

    // R10 zero burst count
    burst_len = 5'd0;
    tx_dma_ack = 1; cyc();
    chk(tx_dma_req, "R10 zero burst ack", tx_dma_req, 1);
    tx_rd_en = 1; cyc();
    chk(tx_dma_req, "R10 req follows level", tx_dma_req, 1);

    // R6 / R7 / R8 receive bursts, threshold = burst - 1
    do_reset();
    burst_len = 5'd8; rx_thresh = 5'd7;
    for (int k = 0; k < 8; k++) begin
      chk(!rx_dma_req, "R6 rx below trigger", rx_dma_req, 0);
      rx_wr_en = 1; rx_wr_data = rxw(k); cyc();
    end
    chk(rx_dma_req, "R6 rx at trigger", rx_dma_req, 1);
    rx_dma_ack = 1; cyc();
    chk(!rx_dma_req, "R7 rx req dropped", rx_dma_req, 0);
    for (int k = 8; k < 12; k++) begin
      rx_wr_en = 1; rx_wr_data = rxw(k); cyc();
    end
    for (int k = 0; k < 8; k++) begin
      chk(!rx_dma_req, "R7 rx req low in burst", rx_dma_req, 0);
      chk(rx_rd_data == rxw(k), "R2 rx burst data", rx_rd_data, rxw(k));
      rx_rd_en = 1; cyc();
    end
    chk(rx_level == 4, "R8 rx level after burst", rx_level, 4);
    chk(!rx_dma_req, "R8 rx req reevaluated low", rx_dma_req, 0);
    chk(!rx_udf, "R8 rx burst no udf", rx_udf, 0);
    for (int k = 12; k < 16; k++) begin
      rx_wr_en = 1; rx_wr_data = rxw(k); cyc();
    end
    chk(rx_dma_req, "R8 rx req returns", rx_dma_req, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule